// File: doc/BRIEF.md
# Frame Viterbi Decoder, Rate 1/2, Seven-Stage Code

This block recovers the data bits of one frame that was coded with a rate 1/2 convolutional code of constraint length 7. Every accepted input pair carries two hard-decided coded bits and moves the 64-state trellis forward by one step. The block keeps a path metric for each state and stores one survivor decision per state per step. It holds the decisions for the whole frame, so no sliding window is needed.

A frame opens with a one-cycle start pulse. The encoder is taken to have begun in the all-zero state. Coded pairs then arrive on a valid/ready handshake. When the last pair of the frame has been accepted, the block stops taking input. It picks the state with the smallest path metric and traces back through the stored decisions, writing each decoded bit into a reversing buffer. The bits then leave one per cycle in their original order. A valid flag marks each output bit and a last flag marks the final one. A new frame may be started on the same cycle as the final output bit.

Top module: `vit_frame_decoder`

## Requirements
- R1: The encoder register is r, where r[0] is the current data bit and r[k] is the data bit from k steps earlier. The coded bits are in_sym[0] = XOR of r[6:0] masked by 7'b1011011 and in_sym[1] = XOR of r[6:0] masked by 7'b1111001. A frame coded this way from the all-zero state, with no errors, decodes to exactly the data sent.
- R2: in_ready is 1 from the cycle after an accepted start until FRAME_LEN pairs have been accepted, and 0 at all other times. A pair is accepted on a rising edge where in_valid and in_ready are both 1. Stalls, where in_valid is low, do not change the result.
- R3: frame_start is accepted only when the block is idle, or in the cycle where out_last is 1. At any other time it is ignored, and the frame in progress continues unchanged.
- R4: The branch metric is the Hamming distance between the received pair and the expected pair of a branch. At frame start, state 0 has metric 0 and every other state has metric INIT_PM. The output equals a maximum-likelihood decode computed with these rules, so isolated single bit errors are corrected.
- R5: When the two candidates in a compare are equal, the predecessor with the lower number wins. Traceback starts from the state with the lowest metric; when several states share that metric, the lowest-numbered one is used.
- R6: out_valid first goes high FRAME_LEN+1 rising edges after the edge that accepts the last pair. It then stays high for exactly FRAME_LEN consecutive cycles, with the bits in input order. out_last is 1 only on the final bit.
- R7: After every step, the metrics are reduced by the previous minimum metric. The smallest metric therefore never exceeds 2, and long noisy frames still decode exactly as an unbounded-metric reference does.
- R8: A synchronous active-low reset returns the block to idle, with in_ready and out_valid at 0, even in the middle of a frame. The next frame then decodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that opens a frame |
| in_valid | input | 1 | A coded pair is present on in_sym |
| in_ready | output | 1 | The block takes a pair this cycle |
| in_sym | input | 2 | Hard-decided coded pair, bit 0 from the first generator |
| out_valid | output | 1 | out_bit holds a decoded bit |
| out_bit | output | 1 | Decoded data bit |
| out_last | output | 1 | Marks the final decoded bit of a frame |

## Verification
Two functions can fall in the same cycle: the last output bit of one frame leaving the block, and the start of the next frame, which reloads the path metrics and clears the step counter. The bench provokes this by holding back a start pulse until it sees out_last, then raising it in that same cycle. A behavioural model, updated on every clock edge, expects in_ready to rise on the next cycle with no lost output bit. It also expects the second frame to decode to its own data, untouched by leftovers from the first frame.

// File: rtl/vit_pkg.sv
// Shared constants, controller state type and code helpers for the
// frame Viterbi decoder. Assumes a rate 1/2 code with two fixed generators.
package vit_pkg;
    localparam int CONSTRAINT_LEN = 7;
    localparam int MEM_W          = CONSTRAINT_LEN - 1;
    localparam int NUM_STATES     = 1 << MEM_W;
    localparam logic [CONSTRAINT_LEN-1:0] TAP_A = 7'b1011011;
    localparam logic [CONSTRAINT_LEN-1:0] TAP_B = 7'b1111001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_SEL,
        ST_TRACE,
        ST_EMIT
    } ctrl_state_t;

    // Expected coded pair for an encoder register (bit 0 = newest data bit)
    function automatic logic [1:0] branch_code(input logic [CONSTRAINT_LEN-1:0] reg_bits);
        branch_code = {^(reg_bits & TAP_B), ^(reg_bits & TAP_A)};
    endfunction

    // Hamming distance between two coded pairs
    function automatic logic [1:0] pair_dist(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] diff;
        diff = a ^ b;
        pair_dist = {1'b0, diff[0]} + {1'b0, diff[1]};
    endfunction
endpackage

// File: rtl/vit_acs_array.sv
// Branch metrics, add-compare-select for every trellis state and the path
// metric registers. Normalises by subtracting the minimum of the registered
// metrics, which keeps every metric small. Also reports the best state, with
// ties going to the lowest index.
module vit_acs_array
    import vit_pkg::*;
#(
    parameter int PM_W    = 8,
    parameter int INIT_PM = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init,
    input  logic                  step,
    input  logic [1:0]            rx_sym,
    output logic [NUM_STATES-1:0] decisions,
    output logic [MEM_W-1:0]      best_state,
    output logic [PM_W-1:0]       best_pm
);
    logic [PM_W-1:0]  pm_q [NUM_STATES];
    logic [PM_W-1:0]  pm_d [NUM_STATES];
    logic [PM_W-1:0]  min_val;
    logic [MEM_W-1:0] min_idx;

    // Scan the registered metrics for the smallest, keeping the lowest index
    always_comb begin
        min_val = pm_q[0];
        min_idx = '0;
        for (int i = 1; i < NUM_STATES; i++) begin
            if (pm_q[i] < min_val) begin
                min_val = pm_q[i];
                min_idx = i[MEM_W-1:0];
            end
        end
    end

    assign best_state = min_idx;
    assign best_pm    = min_val;

    // One ACS unit per next state; predecessor s = {x, ns[5:1]}, input bit = ns[0]
    for (genvar ns = 0; ns < NUM_STATES; ns++) begin : g_acs
        localparam logic [MEM_W-1:0] NS = MEM_W'(ns);
        localparam int PRED_LO = ns >> 1;
        localparam int PRED_HI = (ns >> 1) + NUM_STATES / 2;
        logic [1:0]      code_lo, code_hi;
        logic [PM_W-1:0] cand_lo, cand_hi;

        assign code_lo = branch_code({1'b0, NS});
        assign code_hi = branch_code({1'b1, NS});
        assign cand_lo = pm_q[PRED_LO] - min_val + PM_W'(pair_dist(rx_sym, code_lo));
        assign cand_hi = pm_q[PRED_HI] - min_val + PM_W'(pair_dist(rx_sym, code_hi));
        assign decisions[ns] = (cand_hi < cand_lo);
        assign pm_d[ns]      = decisions[ns] ? cand_hi : cand_lo;
    end

    // Path metric registers: cleared on reset, seeded at frame start, updated per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_STATES; i++) pm_q[i] <= '0;
        end else if (init) begin
            for (int i = 0; i < NUM_STATES; i++) pm_q[i] <= (i == 0) ? '0 : PM_W'(INIT_PM);
        end else if (step) begin
            for (int i = 0; i < NUM_STATES; i++) pm_q[i] <= pm_d[i];
        end
    end
endmodule

// File: rtl/vit_surv_mem.sv
// Survivor decision store: one word of per-state decisions for each trellis
// step of a frame. Written in step order; read asynchronously by traceback.
module vit_surv_mem #(
    parameter int DEPTH = 250,
    parameter int WIDTH = 64,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store the decision word of the current step
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/vit_traceback.sv
// Walks the survivor words from the last step back to the first, one step per
// cycle, and places each decoded bit at its own position in a reversing
// buffer. It then plays the buffer out in input order. Assumes the load
// pulse comes after the final step has been stored.
module vit_traceback
    import vit_pkg::*;
#(
    parameter int FRAME_LEN = 250,
    parameter int AW        = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [MEM_W-1:0]      start_state,
    input  logic                  trace_en,
    input  logic                  emit_en,
    input  logic [NUM_STATES-1:0] surv_row,
    output logic [AW-1:0]         rd_addr,
    output logic                  trace_at_end,
    output logic                  emit_at_end,
    output logic                  dec_bit
);
    logic [MEM_W-1:0]     tb_state;
    logic [AW-1:0]        tb_idx;
    logic [AW-1:0]        emit_idx;
    logic [FRAME_LEN-1:0] rev_buf;

    // Traceback state, step index and playback index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_state <= '0;
            tb_idx   <= '0;
            emit_idx <= '0;
        end else if (load) begin
            tb_state <= start_state;
            tb_idx   <= AW'(FRAME_LEN - 1);
            emit_idx <= '0;
        end else begin
            if (trace_en) begin
                tb_state <= {surv_row[tb_state], tb_state[MEM_W-1:1]};
                if (tb_idx != '0) tb_idx <= tb_idx - 1'b1;
            end
            if (emit_en) emit_idx <= emit_idx + 1'b1;
        end
    end

    // The bit of step t is the newest input bit of the state reached at step t
    always_ff @(posedge clk) begin
        if (trace_en) rev_buf[tb_idx] <= tb_state[0];
    end

    assign rd_addr      = tb_idx;
    assign trace_at_end = (tb_idx == '0);
    assign emit_at_end  = (emit_idx == AW'(FRAME_LEN - 1));
    assign dec_bit      = rev_buf[emit_idx];
endmodule

// File: rtl/vit_frame_decoder.sv
// Top of the frame Viterbi decoder. Sequences one frame: it accepts
// FRAME_LEN coded pairs, selects the best end state, traces back and then
// emits the decoded bits in order. Assumes the encoder starts each frame
// from the all-zero state.
module vit_frame_decoder #(
    parameter int FRAME_LEN = 250,
    parameter int PM_W      = 8,
    parameter int INIT_PM   = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [1:0] in_sym,
    output logic       out_valid,
    output logic       out_bit,
    output logic       out_last
);
    import vit_pkg::*;

    localparam int AW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

    ctrl_state_t           state_q, state_d;
    logic [AW-1:0]         step_cnt;
    logic [NUM_STATES-1:0] decisions, surv_row;
    logic [MEM_W-1:0]      best_state;
    logic [PM_W-1:0]       best_pm;
    logic [AW-1:0]         tb_addr;
    logic                  trace_at_end, emit_at_end, dec_bit;
    logic                  accept, last_accept, frame_go;

    assign in_ready    = (state_q == ST_RUN);
    assign accept      = in_valid && in_ready;
    assign last_accept = accept && (step_cnt == AW'(FRAME_LEN - 1));
    assign frame_go    = frame_start &&
                         ((state_q == ST_IDLE) || ((state_q == ST_EMIT) && emit_at_end));

    // Frame sequencing: idle, accept pairs, pick state, trace back, emit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_go) state_d = ST_RUN;
            ST_RUN:   if (last_accept) state_d = ST_SEL;
            ST_SEL:   state_d = ST_TRACE;
            ST_TRACE: if (trace_at_end) state_d = ST_EMIT;
            ST_EMIT:  if (emit_at_end) state_d = frame_go ? ST_RUN : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Controller state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Survivor write pointer: one slot per accepted trellis step
    always_ff @(posedge clk) begin
        if (!rst_n)      step_cnt <= '0;
        else if (frame_go) step_cnt <= '0;
        else if (accept) step_cnt <= step_cnt + 1'b1;
    end

    vit_acs_array #(
        .PM_W    (PM_W),
        .INIT_PM (INIT_PM)
    ) u_acs (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (frame_go),
        .step       (accept),
        .rx_sym     (in_sym),
        .decisions  (decisions),
        .best_state (best_state),
        .best_pm    (best_pm)
    );

    vit_surv_mem #(
        .DEPTH (FRAME_LEN),
        .WIDTH (NUM_STATES),
        .AW    (AW)
    ) u_surv (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (step_cnt),
        .wr_data (decisions),
        .rd_addr (tb_addr),
        .rd_data (surv_row)
    );

    vit_traceback #(
        .FRAME_LEN (FRAME_LEN),
        .AW        (AW)
    ) u_tb (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (state_q == ST_SEL),
        .start_state  (best_state),
        .trace_en     (state_q == ST_TRACE),
        .emit_en      (state_q == ST_EMIT),
        .surv_row     (surv_row),
        .rd_addr      (tb_addr),
        .trace_at_end (trace_at_end),
        .emit_at_end  (emit_at_end),
        .dec_bit      (dec_bit)
    );

    assign out_valid = (state_q == ST_EMIT);
    assign out_last  = out_valid && emit_at_end;
    assign out_bit   = out_valid && dec_bit;
endmodule

// File: rtl/vit_frame_decoder_chk.sv
// Protocol and metric checks for the frame Viterbi decoder, bound to the top.
module vit_frame_decoder_chk #(
    parameter int PM_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_start,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_last,
    input logic [PM_W-1:0] best_pm
);
    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> ($past(in_valid) || !$past(rst_n)));

    // R2
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R3
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(frame_start));

    // R6
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6
    burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // R7
    metric_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        best_pm <= PM_W'(2));
endmodule

bind vit_frame_decoder vit_frame_decoder_chk #(.PM_W(PM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_last    (out_last),
    .best_pm     (best_pm)
);

// File: tb/vit_frame_decoder_tb.sv
`timescale 1ns/1ps
module vit_frame_decoder_tb;
    localparam int FRAME_LEN = 250;
    localparam int NST       = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_sym = 2'b00;
    logic       in_ready, out_valid, out_bit, out_last;

    always #2 clk = ~clk;

    vit_frame_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
        .in_ready(in_ready), .in_sym(in_sym), .out_valid(out_valid),
        .out_bit(out_bit), .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit armed  = 0;

    bit         src [FRAME_LEN];
    logic [1:0] tx  [FRAME_LEN];
    logic [1:0] m_rx [FRAME_LEN];
    bit         m_exp [FRAME_LEN];
    bit [NST-1:0] dec_tab [FRAME_LEN];
    bit got_q[$];
    bit ref_q[$];
    bit sent_q[$];

    int m_phase = 0, m_cnt = 0, m_wait = 0, m_emit = 0;

    task automatic chk(input bit ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", what, got, exp);
        end
    endtask

    function automatic int par7(input int v);
        int c = 0;
        for (int b = 0; b < 7; b++) c ^= (v >> b) & 1;
        return c;
    endfunction

    // R1 code: bit0 uses mask 0x5B, bit1 uses mask 0x79, r[0] newest
    function automatic logic [1:0] enc_out(input int r);
        return 2'(par7(r & 'h79) * 2 + par7(r & 'h5B));
    endfunction

    function automatic int ham(input logic [1:0] a, input logic [1:0] b);
        return int'(a[0] ^ b[0]) + int'(a[1] ^ b[1]);
    endfunction

    task automatic encode_src();
        int s = 0;
        for (int t = 0; t < FRAME_LEN; t++) begin
            int r;
            r = (s << 1) | int'(src[t]);
            tx[t] = enc_out(r);
            s = r & 63;
        end
    endtask

    // Maximum-likelihood reference with unbounded integer metrics (R4, R5)
    function automatic void ref_decode();
        int pm [NST];
        int nx [NST];
        int best;
        int st;
        for (int s = 0; s < NST; s++) pm[s] = (s == 0) ? 0 : 1000;
        for (int t = 0; t < FRAME_LEN; t++) begin
            for (int ns = 0; ns < NST; ns++) begin
                int m0, m1;
                m0 = pm[ns >> 1] + ham(m_rx[t], enc_out(ns));
                m1 = pm[(ns >> 1) + 32] + ham(m_rx[t], enc_out(ns | 64));
                if (m1 < m0) begin nx[ns] = m1; dec_tab[t][ns] = 1'b1; end
                else         begin nx[ns] = m0; dec_tab[t][ns] = 1'b0; end
            end
            pm = nx;
        end
        best = 0;
        for (int s = 1; s < NST; s++) if (pm[s] < pm[best]) best = s;
        st = best;
        for (int t = FRAME_LEN - 1; t >= 0; t--) begin
            m_exp[t] = bit'(st & 1);
            st = (int'(dec_tab[t][st]) << 5) | (st >> 1);
        end
    endfunction

    // Cycle model of the frame sequence, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_cnt   = 0;
        end else begin
            case (m_phase)
                0: if (frame_start) begin m_phase = 1; m_cnt = 0; end
                1: if (in_valid) begin
                    m_rx[m_cnt] = in_sym;
                    m_cnt++;
                    if (m_cnt == FRAME_LEN) begin
                        ref_decode();
                        for (int k = 0; k < FRAME_LEN; k++) ref_q.push_back(m_exp[k]);
                        m_phase = 2;
                        m_wait  = FRAME_LEN + 1;
                    end
                end
                2: begin
                    m_wait--;
                    if (m_wait == 0) begin m_phase = 3; m_emit = 0; end
                end
                3: begin
                    m_emit++;
                    if (m_emit == FRAME_LEN) begin
                        if (frame_start) begin m_phase = 1; m_cnt = 0; end
                        else m_phase = 0;
                    end
                end
                default: m_phase = 0;
            endcase
        end
    end

    // Per-cycle comparison and output collection, away from the rising edge
    always @(negedge clk) begin
        if (armed) begin
            chk(in_ready === (m_phase == 1), "R2 in_ready", int'(in_ready), int'(m_phase == 1));
            chk(out_valid === (m_phase == 3), "R6 out_valid timing", int'(out_valid), int'(m_phase == 3));
            if (m_phase == 3) begin
                chk(out_bit === m_exp[m_emit], "R4 R5 out_bit", int'(out_bit), int'(m_exp[m_emit]));
                chk(out_last === (m_emit == FRAME_LEN - 1), "R6 out_last", int'(out_last),
                    int'(m_emit == FRAME_LEN - 1));
            end
            if (out_valid === 1'b1) got_q.push_back(out_bit);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got %0d exp %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic fill_random();
        for (int t = 0; t < FRAME_LEN; t++) src[t] = bit'($urandom_range(0, 1));
        encode_src();
    endtask

    task automatic add_noise(input int pct);
        for (int t = 0; t < FRAME_LEN; t++)
            for (int b = 0; b < 2; b++)
                if ($urandom_range(0, 99) < pct) tx[t][b] = ~tx[t][b];
    endtask

    task automatic send_frame(input int gaps, input bit sync_last, input int poke_at);
        int  i = 0;
        bit  acc;
        if (sync_last) begin
            while (out_last !== 1'b1) @(negedge clk);
        end else begin
            repeat (2) @(negedge clk);
        end
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        while (i < FRAME_LEN) begin
            if (gaps != 0 && $urandom_range(0, gaps) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end else begin
                in_valid    = 1'b1;
                in_sym      = tx[i];
                frame_start = (i == poke_at);
                acc         = in_ready;
                @(negedge clk);
                frame_start = 1'b0;
                if (acc) i++;
            end
        end
        in_valid = 1'b0;
        in_sym   = 2'b00;
        for (int k = 0; k < FRAME_LEN; k++) sent_q.push_back(src[k]);
    endtask

    task automatic check_frame(input string tag, input bit clean);
        int bad_ref = 0;
        int bad_src = 0;
        bit g, r, s;
        while (got_q.size() < FRAME_LEN) @(negedge clk);
        for (int k = 0; k < FRAME_LEN; k++) begin
            g = got_q.pop_front();
            r = (ref_q.size() > 0) ? ref_q.pop_front() : ~g;
            s = sent_q.pop_front();
            if (g != r) bad_ref++;
            if (clean && g != s) bad_src++;
        end
        chk(bad_ref == 0, {tag, " frame vs reference, mismatches"}, bad_ref, 0);
        if (clean) chk(bad_src == 0, {tag, " frame vs sent data, mismatches"}, bad_src, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;
        // R8 state after reset
        chk(in_ready === 1'b0, "R8 in_ready after reset", int'(in_ready), 0);
        chk(out_valid === 1'b0, "R8 out_valid after reset", int'(out_valid), 0);

        // R1 error-free random frame
        fill_random();
        send_frame(0, 1'b0, -1);
        check_frame("R1 clean", 1'b1);

        // R1 all-ones data
        for (int t = 0; t < FRAME_LEN; t++) src[t] = 1'b1;
        encode_src();
        send_frame(0, 1'b0, -1);
        check_frame("R1 all ones", 1'b1);

        // R2 stalls on in_valid
        fill_random();
        send_frame(3, 1'b0, -1);
        check_frame("R2 stalled", 1'b1);

        // R4 isolated single errors are corrected
        fill_random();
        tx[20][0]  = ~tx[20][0];
        tx[80][1]  = ~tx[80][1];
        tx[150][0] = ~tx[150][0];
        tx[215][1] = ~tx[215][1];
        send_frame(0, 1'b0, -1);
        check_frame("R4 sparse errors", 1'b1);

        // R7 heavy noise against unbounded reference
        fill_random();
        add_noise(20);
        send_frame(1, 1'b0, -1);
        check_frame("R7 heavy noise", 1'b0);

        // R5 pure random pairs, where equal metrics are frequent
        for (int t = 0; t < FRAME_LEN; t++) tx[t] = 2'($urandom_range(0, 3));
        send_frame(0, 1'b0, -1);
        check_frame("R5 random pairs", 1'b0);

        // R3 in_valid while idle, start pulse mid-frame and during traceback
        in_valid = 1'b1;
        in_sym   = 2'b11;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        fill_random();
        send_frame(0, 1'b0, 100);
        repeat (10) @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check_frame("R3 ignored starts", 1'b1);
        repeat (3) @(negedge clk);
        chk(in_ready === 1'b0, "R3 idle after ignored start", int'(in_ready), 0);

        // R3 R6 back-to-back: new start on the out_last cycle
        fill_random();
        send_frame(0, 1'b0, -1);
        fill_random();
        send_frame(0, 1'b1, -1);
        check_frame("R6 first of pair", 1'b1);
        check_frame("R3 second of pair", 1'b1);

        // R8 reset in the middle of a frame
        repeat (3) @(negedge clk);
        fill_random();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int t = 0; t < 60; t++) begin
            in_valid = 1'b1;
            in_sym   = tx[t];
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(negedge clk);
        rst_n    = 1'b1;
        chk(in_ready === 1'b0, "R8 in_ready after mid-frame reset", int'(in_ready), 0);
        chk(out_valid === 1'b0, "R8 out_valid after mid-frame reset", int'(out_valid), 0);
        fill_random();
        send_frame(0, 1'b0, -1);
        check_frame("R8 after reset", 1'b1);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule